// File: doc/BRIEF.md
# Multi-Controller Two-Wire Bus Byte Transmitter with Arbitration

This block is the controller side of a shared open-drain two-wire serial bus that other controllers may drive at the same time. It takes one command at a time: begin a transfer (start condition), send one byte and collect the acknowledge, or end the transfer (stop condition). It drives each line only by enabling a pull-down (`scl_oe`, `sda_oe`). It reads the real line levels back through `scl_i` and `sda_i`, and every decision about timing and ownership comes from those levels.

The clock low and high phases each last a programmable number of system clocks. The high phase is counted only after the clock line has been seen high, so a target that holds the clock low simply slows the transfer down. On every bit the block sends as a one, it checks the data line in the middle of the high phase. If it finds a zero there, another controller owns the bus. The block then lets go of both lines at once, reports the loss, and treats the bus as busy until it sees a stop condition. The same bus monitor keeps a start command waiting until the bus has gone idle. A byte that the target does not acknowledge is reported in the completion status, and the block then closes the transfer with a stop condition on its own.

Top module: `i2c_arb_tx`

## Requirements
- R1: After reset both line drivers are off, `cmd_ready` is 1, `bus_busy` is 0 and `done` is 0.
- R2: A start command (`cmd_op` = 0) does not drive either line while `bus_busy` is 1. The start condition is issued only after a stop condition has been observed, and this includes the case after a lost arbitration.
- R3: A write command (`cmd_op` = 1) places the 8 bits of `cmd_data` on the data line most significant bit first, one bit per clock pulse.
- R4: The clock is pulled low for `LOW_CYC` system clocks and then released. The `HIGH_CYC` count starts only once the clock line reads high, so a target holding the clock low lengthens the bit without corrupting it.
- R5: After the eighth bit the data line is released for a ninth clock pulse. A low level sampled there is an acknowledge: `done` pulses with `nack` = 0.
- R6: A high level on the ninth pulse makes `done` pulse with `nack` = 1, but only after the block has issued a stop condition by itself, so the bus is idle and both drivers are off at that point.
- R7: If a bit sent as one reads back as zero at mid-high, `arb_lost` pulses for one cycle and both drivers turn off together and stay off. `arb_lost_flag` holds 1 until the next command is accepted, and `done` pulses to end the command.
- R8: The arbitration comparison applies to every bit of every byte, not only the first byte after a start condition.
- R9: `bus_busy` becomes 1 when the data line falls while the clock line is high (start condition), and 0 when the data line rises while the clock line is high (stop condition), whichever controller produced the condition.
- R10: A stop command (`cmd_op` = 2) pulls the data line low while the clock line is low, releases the clock, and then releases the data line while the clock line is high. It pulses `done` once the bus is idle.
- R11: `cmd_ready` is 0 from the cycle after a command is accepted until its `done` pulse. `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when `cmd_ready` is 1 |
| cmd_op | input | 2 | 0 start, 1 write byte, 2 stop |
| cmd_data | input | DATA_W | Byte for a write command |
| cmd_ready | output | 1 | Block idle and able to take a command |
| scl_i | input | 1 | Clock line level read back |
| sda_i | input | 1 | Data line level read back |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| done | output | 1 | One-cycle pulse at the end of a command |
| nack | output | 1 | Last write was not acknowledged |
| arb_lost | output | 1 | One-cycle pulse on lost arbitration |
| arb_lost_flag | output | 1 | Lost arbitration during the current or last command |
| bus_busy | output | 1 | Start seen and no stop yet |

## Verification
The write path is driven with bytes that have different bit mixes (0xB5, 0x4A, 0x5A, 0x3C). A scoreboard compares each one with the byte that a bus target model reassembles from the clock edges, which shows whether the bit order is correct. The same bytes are then sent under different target behaviour: an acknowledging target, a silent target, and a target that holds the clock for 40 cycles inside one byte. These runs separate the acknowledge path, the automatic stop after a missing acknowledge, and the stretch handling. A rival controller pulls the data line low on the first bit after a start condition in one run and on the third bit of a second byte in another. This shows that the comparison covers every byte, and a start held during external bus traffic shows that the block waits for a stop condition.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;
  typedef enum logic [1:0] {
    K_START = 2'd0,
    K_BIT   = 2'd1,
    K_ACK   = 2'd2,
    K_STOP  = 2'd3
  } bit_kind_e;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_STOP  = 2'd2;
endpackage

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy
);
  logic scl_q, sda_q;
  logic start_det, stop_det;

  // start: data falls with clock high; stop: data rises with clock high
  assign start_det = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det  = scl_s && scl_q && !sda_q && sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_det)     busy <= 1'b1;
      else if (stop_det) busy <= 1'b0;
    end
  end

  p_busy_on_start_r9: assert property (@(posedge clk) disable iff (rst)
    start_det |=> busy);
  p_idle_on_stop_r9: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !busy);
endmodule

// File: rtl/i2c_bit_eng.sv
module i2c_bit_eng
  import i2c_arb_pkg::*;
#(
  parameter int LOW_CYC  = 8,
  parameter int HIGH_CYC = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      go,
  input  bit_kind_e kind,
  input  logic      val,
  input  logic      scl_s,
  input  logic      sda_s,
  output logic      done,
  output logic      rx,
  output logic      lost,
  output logic      scl_oe,
  output logic      sda_oe
);
  localparam int TMAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LOW_END  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_END = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] MID      = CW'(HIGH_CYC / 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_LOW, S_RISE, S_HIGH, S_FREE} st_e;
  st_e           st;
  logic [CW-1:0] cnt;
  bit_kind_e     kind_q;
  logic          val_q;
  logic          mismatch;

  assign mismatch = (kind_q == K_BIT) && val_q && !sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      kind_q <= K_START;
      val_q  <= 1'b1;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
      done   <= 1'b0;
      lost   <= 1'b0;
      rx     <= 1'b1;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          kind_q <= kind;
          val_q  <= val;
          cnt    <= '0;
          if (kind == K_START) begin
            sda_oe <= 1'b1;
            st     <= S_START;
          end else begin
            scl_oe <= 1'b1;
            sda_oe <= (kind == K_STOP) ? 1'b1 : !val;
            st     <= S_LOW;
          end
        end
        S_START: begin
          if (cnt == HIGH_END) begin
            scl_oe <= 1'b1;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_LOW: begin
          if (cnt == LOW_END) begin
            scl_oe <= 1'b0;
            st     <= S_RISE;
          end else cnt <= cnt + 1'b1;
        end
        S_RISE: if (scl_s) begin
          cnt <= '0;
          st  <= S_HIGH;
        end
        S_HIGH: begin
          if (cnt == MID) rx <= sda_s;
          if (cnt == MID && mismatch) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            lost   <= 1'b1;
            done   <= 1'b1;
            st     <= S_IDLE;
          end else if (cnt == HIGH_END) begin
            if (kind_q == K_STOP) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= S_FREE;
            end else begin
              scl_oe <= 1'b1;
              done   <= 1'b1;
              st     <= S_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_FREE: begin
          if (cnt == HIGH_END) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // clock held low by a target: keep waiting and keep the driver off
  p_stretch_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_RISE && !scl_s) |=> (st == S_RISE && !scl_oe));
  p_release_on_loss_r7: assert property (@(posedge clk) disable iff (rst)
    lost |-> (!scl_oe && !sda_oe));
  p_high_count_after_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (st == S_HIGH && cnt == '0) |-> $past(scl_s));
endmodule

// File: rtl/i2c_arb_tx.sv
module i2c_arb_tx
  import i2c_arb_pkg::*;
#(
  parameter int LOW_CYC  = 8,
  parameter int HIGH_CYC = 8,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              cmd_ready,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic              nack,
  output logic              arb_lost,
  output logic              arb_lost_flag,
  output logic              bus_busy
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  typedef enum logic [2:0] {T_IDLE, T_WAIT, T_START, T_DATA, T_ACK, T_STOP} top_e;
  top_e              st;
  logic              scl_s, sda_s;
  logic              go;
  bit_kind_e         kind;
  logic              val;
  logic [DATA_W-1:0] shreg;
  logic [BW-1:0]     bitn;
  logic              e_done, e_rx, e_lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_s <= 1'b1;
      sda_s <= 1'b1;
    end else begin
      scl_s <= scl_i;
      sda_s <= sda_i;
    end
  end

  i2c_bus_watch u_watch (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .busy(bus_busy)
  );

  i2c_bit_eng #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_eng (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .val(val),
    .scl_s(scl_s), .sda_s(sda_s), .done(e_done), .rx(e_rx), .lost(e_lost),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign cmd_ready = (st == T_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= T_IDLE;
      go            <= 1'b0;
      kind          <= K_START;
      val           <= 1'b1;
      shreg         <= '0;
      bitn          <= '0;
      done          <= 1'b0;
      nack          <= 1'b0;
      arb_lost      <= 1'b0;
      arb_lost_flag <= 1'b0;
    end else begin
      go       <= 1'b0;
      done     <= 1'b0;
      arb_lost <= e_lost;
      if (e_lost) arb_lost_flag <= 1'b1;
      case (st)
        T_IDLE: if (cmd_valid) begin
          arb_lost_flag <= 1'b0;
          nack          <= 1'b0;
          case (cmd_op)
            OP_START: st <= T_WAIT;
            OP_WRITE: begin
              go    <= 1'b1;
              kind  <= K_BIT;
              val   <= cmd_data[DATA_W-1];
              shreg <= cmd_data << 1;
              bitn  <= '0;
              st    <= T_DATA;
            end
            OP_STOP: begin
              go   <= 1'b1;
              kind <= K_STOP;
              st   <= T_STOP;
            end
            default: st <= T_IDLE;
          endcase
        end
        T_WAIT: if (!bus_busy) begin
          go   <= 1'b1;
          kind <= K_START;
          st   <= T_START;
        end
        T_START: if (e_done) begin
          done <= 1'b1;
          st   <= T_IDLE;
        end
        T_DATA: if (e_done) begin
          if (e_lost) begin
            done <= 1'b1;
            st   <= T_IDLE;
          end else if (bitn == LAST_BIT) begin
            go   <= 1'b1;
            kind <= K_ACK;
            val  <= 1'b1;
            st   <= T_ACK;
          end else begin
            bitn  <= bitn + 1'b1;
            go    <= 1'b1;
            kind  <= K_BIT;
            val   <= shreg[DATA_W-1];
            shreg <= shreg << 1;
          end
        end
        T_ACK: if (e_done) begin
          if (e_rx) begin
            nack <= 1'b1;
            go   <= 1'b1;
            kind <= K_STOP;
            st   <= T_STOP;
          end else begin
            done <= 1'b1;
            st   <= T_IDLE;
          end
        end
        T_STOP: if (e_done) begin
          done <= 1'b1;
          st   <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  p_quiet_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (st == T_WAIT && bus_busy) |=> (!scl_oe && !sda_oe));
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_loss_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> !arb_lost);
  p_loss_flag_r7: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> arb_lost_flag);
endmodule

// File: tb/tb_i2c_arb_tx.sv
module tb_i2c_arb_tx;
  localparam int LOW_CYC  = 8;
  localparam int HIGH_CYC = 8;
  localparam int STRETCH  = 40;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic       cmd_ready, scl_oe, sda_oe, done, nack, arb_lost, arb_lost_flag, bus_busy;
  logic       scl_line, sda_line;

  // bench-owned line pull-downs
  logic tgt_sda_low = 1'b0, tgt_scl_low = 1'b0, rival_low = 1'b0;
  logic ext_low = 1'b0;
  // control knobs written only by the stimulus process
  logic ack_en = 1'b1, rival_en = 1'b0, stretch_req = 1'b0;
  int   rival_bit = 0, stretch_bit = 3;

  always #5 clk = ~clk;

  assign scl_line = !(scl_oe || tgt_scl_low);
  assign sda_line = !(sda_oe || tgt_sda_low || rival_low || ext_low);

  i2c_arb_tx #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC), .DATA_W(8)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_ready(cmd_ready), .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .done(done), .nack(nack), .arb_lost(arb_lost),
    .arb_lost_flag(arb_lost_flag), .bus_busy(bus_busy)
  );

  // expected-byte queue: driver writes, monitor reads
  logic [7:0] exp_mem [0:63];
  int exp_wr = 0;
  int sb_rd = 0, sb_checks = 0, sb_fails = 0;
  int tb_checks = 0, tb_fails = 0;
  int done_cnt = 0, arb_cnt = 0;
  bit finished = 0;

  // bus target / monitor model
  logic p_scl = 1'b1, p_sda = 1'b1, stretch_used = 1'b0;
  logic [7:0] cap = '0;
  int rise_cnt = 0, s_cnt = 0;
  always @(negedge clk) begin
    logic s, d;
    s = scl_line;
    d = sda_line;
    if (rst) begin
      rise_cnt = 0; tgt_sda_low = 0; tgt_scl_low = 0; rival_low = 0; stretch_used = 0;
    end else begin
      if (p_scl && s && p_sda && !d) rise_cnt = 0;
      if (!p_scl && s) begin
        if (rise_cnt < 8) cap = {cap[6:0], d};
        rise_cnt++;
        if (rise_cnt == 8) begin
          sb_checks++;
          if (sb_rd >= exp_wr) begin
            sb_fails++;
            $display("FAIL R3: unexpected byte act=%02h exp=none", cap);
          end else begin
            if (cap !== exp_mem[sb_rd]) begin
              sb_fails++;
              $display("FAIL R3: byte on bus act=%02h exp=%02h", cap, exp_mem[sb_rd]);
            end
            sb_rd++;
          end
        end
      end
      if (p_scl && !s) begin
        if (rise_cnt == 8) tgt_sda_low = ack_en;
        if (rise_cnt == 9) begin tgt_sda_low = 0; rise_cnt = 0; end
        if (rival_en && rise_cnt == rival_bit) rival_low = 1;
        if (stretch_req && !stretch_used && rise_cnt == stretch_bit) begin
          tgt_scl_low = 1; s_cnt = STRETCH; stretch_used = 1;
        end
      end
      if (tgt_scl_low) begin
        if (s_cnt == 0) tgt_scl_low = 0; else s_cnt--;
      end
      if (!rival_en) rival_low = 0;
      if (!stretch_req) stretch_used = 0;
      if (done) done_cnt++;
      if (arb_lost) arb_cnt++;
    end
    p_scl = s;
    p_sda = d;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tb_checks++;
    if (!ok) begin
      tb_fails++;
      $display("FAIL %s: %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] data);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = data;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic push(input logic [7:0] b);
    exp_mem[exp_wr] = b;
    exp_wr++;
  endtask

  task automatic wait_done(output bit got, output bit nk, output int cyc);
    got = 0; nk = 0; cyc = 0;
    for (int i = 0; i < 20000; i++) begin
      if (done) begin got = 1; nk = nack; cyc = i; return; end
      @(negedge clk);
    end
  endtask

  initial begin
    bit got, nk;
    int cyc, t_plain, t_str, dc0, ac0;
    rst = 1; cmd_valid = 0; cmd_op = 0; cmd_data = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(cmd_ready && !bus_busy && !done, "R1", "ready/busy/done", {cmd_ready, bus_busy, done}, 3'b100);
    check(!scl_oe && !sda_oe, "R1", "drivers off", {scl_oe, sda_oe}, 0);

    // start on idle bus
    issue(2'd0, 8'h00);
    check(!cmd_ready, "R11", "ready low while running", cmd_ready, 0);
    wait_done(got, nk, cyc);
    check(got, "R11", "start done", got, 1);
    @(negedge clk);
    check(bus_busy, "R9", "busy after own start", bus_busy, 1);

    // acknowledged byte
    push(8'hB5);
    issue(2'd1, 8'hB5);
    wait_done(got, nk, t_plain);
    check(got && !nk, "R5", "ack status", {got, nk}, 2'b10);
    @(negedge clk);
    check(!done, "R11", "done single pulse", done, 0);

    // stretched byte
    stretch_req = 1;
    push(8'h4A);
    issue(2'd1, 8'h4A);
    wait_done(got, nk, t_str);
    stretch_req = 0;
    check(got && !nk, "R4", "stretched byte ack", {got, nk}, 2'b10);
    check((t_str - t_plain) >= STRETCH - LOW_CYC - 4, "R4", "stretch lengthens byte", t_str - t_plain, STRETCH - LOW_CYC);

    // stop
    issue(2'd2, 8'h00);
    wait_done(got, nk, cyc);
    check(got, "R10", "stop done", got, 1);
    check(!bus_busy && !scl_oe && !sda_oe, "R10", "bus idle after stop", {bus_busy, scl_oe, sda_oe}, 0);

    // no acknowledge: automatic stop
    issue(2'd0, 8'h00);
    wait_done(got, nk, cyc);
    ack_en = 0;
    push(8'h5A);
    issue(2'd1, 8'h5A);
    wait_done(got, nk, cyc);
    check(got && nk, "R6", "nack status", {got, nk}, 2'b11);
    check(!bus_busy && !scl_oe && !sda_oe, "R6", "auto stop freed bus", {bus_busy, scl_oe, sda_oe}, 0);
    ack_en = 1;
    repeat (5) @(negedge clk);

    // start held off by foreign traffic
    ext_low = 1;
    repeat (5) @(negedge clk);
    check(bus_busy, "R9", "busy on foreign start", bus_busy, 1);
    dc0 = done_cnt;
    issue(2'd0, 8'h00);
    repeat (60) @(negedge clk);
    check(!scl_oe && !sda_oe && done_cnt == dc0, "R2", "start held while busy", {scl_oe, sda_oe}, 0);
    ext_low = 0;
    wait_done(got, nk, cyc);
    check(got, "R2", "start after foreign stop", got, 1);
    @(negedge clk);
    check(bus_busy && sda_oe, "R2", "own start on bus", {bus_busy, sda_oe}, 2'b11);
    issue(2'd2, 8'h00);
    wait_done(got, nk, cyc);
    repeat (5) @(negedge clk);

    // arbitration lost on first bit
    rival_bit = 0;
    rival_en = 1;
    issue(2'd0, 8'h00);
    wait_done(got, nk, cyc);
    ac0 = arb_cnt;
    issue(2'd1, 8'hB5);
    wait_done(got, nk, cyc);
    @(negedge clk);
    check(arb_cnt == ac0 + 1, "R7", "one loss pulse", arb_cnt - ac0, 1);
    check(arb_lost_flag, "R7", "loss flag set", arb_lost_flag, 1);
    check(!scl_oe && !sda_oe, "R7", "drivers off after loss", {scl_oe, sda_oe}, 0);
    repeat (30) @(negedge clk);
    check(!scl_oe && !sda_oe && arb_lost_flag, "R7", "still off, flag kept", {scl_oe, sda_oe, arb_lost_flag}, 1);
    check(bus_busy, "R9", "bus busy after loss", bus_busy, 1);
    dc0 = done_cnt;
    issue(2'd0, 8'h00);
    check(!arb_lost_flag, "R7", "flag cleared by next command", arb_lost_flag, 0);
    repeat (40) @(negedge clk);
    check(!sda_oe && done_cnt == dc0, "R2", "no retry before stop", sda_oe, 0);
    rival_en = 0;
    wait_done(got, nk, cyc);
    check(got, "R2", "retry after stop", got, 1);

    // arbitration lost inside a second byte
    push(8'h3C);
    issue(2'd1, 8'h3C);
    wait_done(got, nk, cyc);
    check(got && !nk, "R5", "first byte ack", {got, nk}, 2'b10);
    rival_bit = 2;
    rival_en = 1;
    ac0 = arb_cnt;
    issue(2'd1, 8'hE0);
    wait_done(got, nk, cyc);
    @(negedge clk);
    check(arb_cnt == ac0 + 1 && arb_lost_flag, "R8", "loss in data byte", arb_cnt - ac0, 1);
    check(!scl_oe && !sda_oe, "R8", "drivers off", {scl_oe, sda_oe}, 0);
    rival_en = 0;
    repeat (20) @(negedge clk);
    check(!bus_busy, "R9", "idle after rival stop", bus_busy, 1'b0);
    check(sb_rd == exp_wr, "R3", "all bytes seen", sb_rd, exp_wr);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", tb_checks + sb_checks, tb_fails + sb_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", tb_checks + sb_checks + 1, tb_fails + sb_fails + 1);
      $finish;
    end
  end
endmodule